// File: doc/BRIEF.md
# Bitstream CIC Decimator

This block turns the one-bit output of an oscillator-based delta-sigma modulator into 20-bit signed samples. Every accepted input bit is mapped to +1 or -1 and fed into a fourth-order cascaded integrator-comb filter. The filter decimates by 8000, so one output sample is produced for every 8000 accepted bits. The combs use a differential delay of one decimated sample.

Each finished sample is truncated to its top 20 bits and pushed into an eight-entry FIFO. A consumer, usually a register read path, drains the FIFO through a valid/ready output. The input side accepts a bit whenever `bit_valid` is high, and `bit_ready` is tied high, because the modulator cannot be stalled. Cycles with `bit_valid` low are idle and do not advance the filter.

On the output side, `out_valid` is high whenever the FIFO is non-empty, and a transfer (pop) happens on a cycle where both `out_valid` and `out_ready` are high. Asserting `out_ready` while the FIFO is empty is allowed: `out_data` reads zero and nothing changes. The producer is never held back. When the FIFO is full, a new sample is discarded and a sticky overflow flag is raised.

Top module: `bitstream_cic_decim`

## Requirements
- R1: An input bit of 1 enters the first integrator as +1, and a bit of 0 enters as -1.
- R2: Exactly one sample is produced per 8000 accepted bits (cycles with `bit_valid` high). Cycles with `bit_valid` low do not advance the decimation phase or the integrators.
- R3: The decimation phase is zero after reset. No sample appears before the 8000th accepted bit, and the first sample reaches the FIFO within 12 cycles after that bit.
- R4: The integrator and comb registers are 53 bits wide. A constant input of all ones settles to the full gain of 8000^4, and a constant input of all zeros settles to -(8000^4), both with no wrap-around error.
- R5: `out_data` is bits 52 down to 33 of the 53-bit comb result, truncated toward minus infinity. A steady all-ones input reads 0x746A5 (+476837), and a steady all-zeros input reads 0x8B95A (-476838).
- R6: A steady alternating 1,0 input settles to an output of exactly 0.
- R7: The FIFO holds up to 8 samples in arrival order. `out_valid` is high exactly when `fifo_level` is non-zero, and a pop happens when `out_valid` and `out_ready` are both high.
- R8: When the FIFO already holds 8 samples, a new sample is dropped, the stored samples are kept, and `fifo_ovf` goes high and stays high until reset.
- R9: While the FIFO is empty, `out_data` reads zero, and asserting `out_ready` changes nothing.
- R10: `bit_ready` is always high.
- R11: After reset, `fifo_level` is 0, `out_valid` is 0, `fifo_ovf` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Input bit present this cycle |
| bit_data | input | 1 | Modulator bit |
| bit_ready | output | 1 | Always high; no input back-pressure |
| out_valid | output | 1 | FIFO holds at least one sample |
| out_ready | input | 1 | Consumer takes the head sample (read strobe) |
| out_data | output | 20 | Head sample, or zero when the FIFO is empty |
| fifo_level | output | 4 | Number of stored samples, 0 to 8 |
| fifo_ovf | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench targets the following corner cases:

- **Decimation phase.** The bench stops after 7999 bits and then adds the 8000th bit. A counter that is off by one, or that counts idle cycles, produces a sample too early or too late.
- **Full-scale constant inputs.** These expose registers that are too narrow, which wrap to a wrong sign. They also expose a wrong truncation slice or a swapped bit mapping, each of which moves the settled values away from 0x746A5 and 0x8B95A.
- **Alternating input.** This reveals a wrong comb delay or a broken stage ordering, which would leave a non-zero residue.
- **Full FIFO and empty reads.** Filling the FIFO past eight samples catches a FIFO that overwrites data or loses the sticky flag. Reads with the FIFO empty catch a design that returns stale data or corrupts its level.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;

  // Register width for an N-stage CIC at a given ratio: N*ceil(log2 R) of growth plus a sign bit.
  function automatic int cic_acc_width(input int stages, input int ratio);
    return stages * $clog2(ratio) + 1;
  endfunction

  // Width of an occupancy counter that must reach the value "depth".
  function automatic int level_width(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int STAGES = 4,
  parameter int ACC_W  = 53
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    in_bit,
  output logic signed [ACC_W-1:0] acc_out
);

  logic signed [ACC_W-1:0] unit_val;
  logic signed [ACC_W-1:0] stage_q [STAGES+1];

  // A 1 bit enters as +1; a 0 bit enters as -1 (all ones).
  assign unit_val   = in_bit ? ACC_W'(1) : {ACC_W{1'b1}};
  assign stage_q[0] = unit_val;

  for (genvar g = 0; g < STAGES; g++) begin : g_integ
    logic signed [ACC_W-1:0] sum_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sum_r <= '0;
      else if (en) sum_r <= sum_r + stage_q[g];
    end
    assign stage_q[g+1] = sum_r;
  end

  assign acc_out = stage_q[STAGES];

endmodule

// File: rtl/cic_phase_counter.sv
module cic_phase_counter #(
  parameter int RATIO = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic dec_stb
);

  localparam int CNT_W = $clog2(RATIO);

  logic [CNT_W-1:0] phase_r;
  logic             wrap;

  assign wrap = (phase_r == CNT_W'(RATIO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_r <= '0;
      dec_stb <= 1'b0;
    end else begin
      dec_stb <= en && wrap;
      if (en) phase_r <= wrap ? '0 : phase_r + 1'b1;
    end
  end

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int STAGES = 4,
  parameter int ACC_W  = 53,
  parameter int OUT_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_stb,
  input  logic signed [ACC_W-1:0] din,
  output logic                    out_stb,
  output logic        [OUT_W-1:0] dout
);

  localparam int DROP = ACC_W - OUT_W;

  logic [STAGES-1:0]       stb_q;
  logic [STAGES-1:0]       stage_en;
  logic signed [ACC_W-1:0] link [STAGES];

  assign link[0]     = din;
  assign stage_en[0] = in_stb;
  if (STAGES > 1) begin : g_en
    assign stage_en[STAGES-1:1] = stb_q[STAGES-2:0];
  end

  // Each stage fires one cycle after the previous one, so the whole chain resolves in STAGES cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= {stb_q[STAGES-2:0], in_stb};
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    logic signed [ACC_W-1:0] hold_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold_r <= '0;
      else if (stage_en[g]) hold_r <= link[g];
    end
    if (g < STAGES - 1) begin : g_mid
      logic signed [ACC_W-1:0] diff_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           diff_r <= '0;
        else if (stage_en[g]) diff_r <= link[g] - hold_r;
      end
      assign link[g+1] = diff_r;
    end else begin : g_last
      logic [OUT_W-1:0] trunc_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           trunc_r <= '0;
        else if (stage_en[g]) trunc_r <= OUT_W'((link[g] - hold_r) >>> DROP);
      end
      assign dout = trunc_r;
    end
  end

  assign out_stb = stb_q[STAGES-1];

endmodule

// File: rtl/cic_sample_fifo.sv
module cic_sample_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               push,
  input  logic [W-1:0]                       push_data,
  input  logic                               pop_req,
  output logic                               head_valid,
  output logic [W-1:0]                       head_data,
  output logic [cic_decim_pkg::level_width(DEPTH)-1:0] level,
  output logic                               ovf
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = cic_decim_pkg::level_width(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop;

  assign full       = (level == LVL_W'(DEPTH));
  assign head_valid = (level != '0);
  assign do_push    = push && !full;
  assign do_pop     = pop_req && head_valid;
  assign head_data  = head_valid ? mem[rd_ptr] : '0;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/bitstream_cic_decim.sv
module bitstream_cic_decim #(
  parameter int STAGES     = 4,
  parameter int RATIO      = 8000,
  parameter int OUT_W      = 20,
  parameter int FIFO_DEPTH = 8,
  localparam int ACC_W     = cic_decim_pkg::cic_acc_width(STAGES, RATIO),
  localparam int LVL_W     = cic_decim_pkg::level_width(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic [LVL_W-1:0] fifo_level,
  output logic             fifo_ovf
);

  logic                    dec_stb;
  logic                    smp_stb;
  logic signed [ACC_W-1:0] integ_out;
  logic [OUT_W-1:0]        smp_data;

  assign bit_ready = 1'b1;

  cic_integ_chain #(.STAGES(STAGES), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(bit_valid), .in_bit(bit_data), .acc_out(integ_out)
  );

  cic_phase_counter #(.RATIO(RATIO)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(bit_valid), .dec_stb(dec_stb)
  );

  cic_comb_chain #(.STAGES(STAGES), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .in_stb(dec_stb), .din(integ_out),
    .out_stb(smp_stb), .dout(smp_data)
  );

  cic_sample_fifo #(.W(OUT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(smp_stb), .push_data(smp_data),
    .pop_req(out_ready), .head_valid(out_valid), .head_data(out_data),
    .level(fifo_level), .ovf(fifo_ovf)
  );

endmodule

// File: rtl/cic_decim_checker.sv
module cic_decim_checker #(
  parameter int OUT_W = 20,
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_ovf
);

  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n) bit_ready);

  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= DEPTH);

  a_r7_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_level) <= int'($past(fifo_level)) + 1) &&
    (int'(fifo_level) + 1 >= int'($past(fifo_level))));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_level) == DEPTH && !out_ready) |=> int'(fifo_level) == DEPTH);

  a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);

endmodule

bind bitstream_cic_decim cic_decim_checker #(
  .OUT_W(OUT_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_ready(bit_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .fifo_level(fifo_level), .fifo_ovf(fifo_ovf)
);

// File: tb/bitstream_cic_decim_tb.sv
module bitstream_cic_decim_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RATIO      = 8000;
  localparam int DEPTH      = 8;
  localparam int OUT_W      = 20;
  localparam int ACC_W      = 53;
  localparam int SETTLE     = 15;
  localparam int WDOG       = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0, out_ready = 1'b0;
  logic bit_ready, out_valid, fifo_ovf;
  logic [OUT_W-1:0] out_data;
  logic [3:0] fifo_level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic alt_q = 1'b1;
  longint gain, pos_exp, neg_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_cic_decim u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fifo_level(fifo_level), .fifo_ovf(fifo_ovf)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [OUT_W-1:0] v);
    return longint'($signed(v));
  endfunction

  // mode 0: zeros, 1: ones, 2: alternating
  task automatic feed(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      if (mode == 2) begin bit_data = alt_q; alt_q = ~alt_q; end
      else bit_data = (mode == 1);
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(output logic [OUT_W-1:0] v);
    @(negedge clk);
    out_ready = 1'b1;
    v = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 level", fifo_level, 0);
    check("R11 valid", out_valid, 0);
    check("R11 ovf", fifo_ovf, 0);
    check("R11 data", out_data, 0);
    check("R10 ready", bit_ready, 1);
  endtask

  task automatic t_phase;
    feed(RATIO - 1, 1);
    idle(SETTLE);
    check("R3 no sample before 8000th bit", fifo_level, 0);
    feed(1, 1);
    idle(SETTLE);
    check("R3 first sample after 8000th bit", fifo_level, 1);
    check("R7 valid with data", out_valid, 1);
  endtask

  task automatic t_fill_overflow;
    logic [OUT_W-1:0] v [DEPTH];
    feed(RATIO * (DEPTH - 1), 1);
    idle(SETTLE);
    check("R7 level full", fifo_level, DEPTH);
    check("R8 no ovf yet", fifo_ovf, 0);
    feed(RATIO, 1);
    idle(SETTLE);
    check("R8 level kept", fifo_level, DEPTH);
    check("R8 ovf set", fifo_ovf, 1);
    for (int i = 0; i < DEPTH; i++) pop(v[i]);
    check("R7 order rising", longint'(sx(v[0]) < sx(v[1])), 1);
    for (int i = 4; i < DEPTH; i++) begin
      check("R1 R4 R5 ones settled", sx(v[i]), pos_exp);
    end
    check("R8 dropped sample absent", fifo_level, 0);
    check("R8 ovf sticky", fifo_ovf, 1);
  endtask

  task automatic t_empty_read;
    logic [OUT_W-1:0] v;
    pop(v);
    check("R9 empty read zero", v, 0);
    idle(2);
    check("R9 level unchanged", fifo_level, 0);
    check("R9 valid low", out_valid, 0);
  endtask

  task automatic t_zeros;
    logic [OUT_W-1:0] v;
    // R2: idle gap inside a block must not shift the phase
    feed(RATIO / 2, 0);
    idle(50);
    check("R2 no sample mid block", fifo_level, 0);
    feed(RATIO / 2, 0);
    idle(SETTLE);
    check("R2 one sample per 8000 bits", fifo_level, 1);
    pop(v);
    for (int k = 0; k < 4; k++) begin
      feed(RATIO, 0);
      idle(SETTLE);
      pop(v);
    end
    check("R1 R4 R5 zeros settled", sx(v), neg_exp);
  endtask

  task automatic t_alternating;
    logic [OUT_W-1:0] v;
    for (int k = 0; k < 5; k++) begin
      feed(RATIO, 2);
      idle(SETTLE);
      check("R2 one sample per block", fifo_level, 1);
      pop(v);
    end
    check("R6 alternating gives zero", sx(v), 0);
  endtask

  initial begin
    gain    = longint'(RATIO) * RATIO * RATIO * RATIO;
    pos_exp = gain >>> (ACC_W - OUT_W);
    neg_exp = (-gain) >>> (ACC_W - OUT_W);
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_phase;
    t_fill_overflow;
    t_empty_read;
    t_zeros;
    t_alternating;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule